// File: doc/BRIEF.md
# Packed Lane Adder/Subtractor

This unit adds or subtracts two 64-bit operands as a row of independent lanes. Each operation picks its lane width (eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes) and an overflow policy. The policy is either modular wraparound, clamping to the signed range of the lane, or clamping to the unsigned range of the lane. No carry or borrow crosses a lane boundary. Subtraction always takes the second operand away from the first.

The operands and controls are captured on every rising clock edge, and the lane results appear on `result` one cycle later. The unit raises no overflow, carry or exception signal. Its only extra output, `bad_cfg`, marks a control combination that has no meaning. When `bad_cfg` is set, `result` is forced to zero.

Top module: `packed_addsub`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first capture, `result` and `bad_cfg` are 0.
- R2: The result for the inputs present at clock edge k appears at the edge k+1. Each lane is computed only from the same lane of `opa` and `opb`, with no carry between lanes. `lane_sel` selects the lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, and 3 is not a legal value.
- R3: When `sat_sel` is 0 (wraparound), each lane holds the low lane-width bits of its sum or difference, and the carry or borrow out is dropped. For example, 8-bit 0xFF+0x01 gives 0x00.
- R4: When `sat_sel` is 1 (signed clamp), a lane whose true signed result is above the range gives 0x7F or 0x7FFF. A lane whose true result is below the range gives 0x80 or 0x8000.
- R5: When `sat_sel` is 2 (unsigned clamp), a lane whose true unsigned result is above the range gives 0xFF or 0xFFFF. A lane whose true result is below zero gives 0x00 or 0x0000.
- R6: `sub_en`=1 computes `opa` minus `opb` in each lane, and `sub_en`=0 computes the sum.
- R7: A captured combination is illegal if `lane_sel`=3, or `sat_sel`=3, or `sat_sel` is nonzero while `lane_sel`=2. An illegal combination sets `bad_cfg`=1 and gives `result`=0 in the next cycle.
- R8: A legal combination gives `bad_cfg`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset that clears the outputs |
| opa | input | 64 | First operand (the minuend when subtracting) |
| opb | input | 64 | Second operand (the subtrahend when subtracting) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| lane_sel | input | 2 | Lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| sat_sel | input | 2 | Overflow policy: 0 = wrap, 1 = signed clamp, 2 = unsigned clamp, 3 = illegal |
| result | output | 64 | Registered lane results |
| bad_cfg | output | 1 | Registered flag for an illegal control combination |

## Verification
The properties assume that every input carries a known 0/1 value on each clock edge after reset is released. The assertions compare the outputs with the inputs sampled one edge earlier. An undriven or X control would make those implications meaningless. The bench sets every input to a defined value before reset is released. It then changes the inputs only on falling edges, so each rising edge captures one complete, settled combination. This covers all four lane codes, all four policy codes and both operations.

// File: rtl/packed_addsub.sv
module packed_addsub #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          sub_en,
  input  logic [1:0]    lane_sel,
  input  logic [1:0]    sat_sel,
  output logic [DW-1:0] result,
  output logic          bad_cfg
);

  localparam int NSZ = 3;

  logic [NSZ-1:0][DW-1:0] per_size;
  logic                   legal;
  logic [DW-1:0]          nxt;

  assign legal = (lane_sel != 2'd3) && (sat_sel != 2'd3) &&
                 !((sat_sel != 2'd0) && (lane_sel == 2'd2));

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int LW = 8 << g;
    localparam int NL = DW / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] a_l, b_l, wrap_l, ssat_l, usat_l;
      logic [LW:0]   xa, xb, s;
      logic          ext_a, ext_b;

      assign a_l   = opa[l*LW +: LW];
      assign b_l   = opb[l*LW +: LW];
      assign ext_a = (sat_sel == 2'd1) & a_l[LW-1];
      assign ext_b = (sat_sel == 2'd1) & b_l[LW-1];
      assign xa    = {ext_a, a_l};
      assign xb    = {ext_b, b_l};
      assign s     = sub_en ? (xa - xb) : (xa + xb);

      assign wrap_l = s[LW-1:0];
      assign ssat_l = (s[LW] ^ s[LW-1]) ? {s[LW], {(LW-1){~s[LW]}}} : s[LW-1:0];
      assign usat_l = s[LW] ? {LW{~sub_en}} : s[LW-1:0];

      always_comb begin
        case (sat_sel)
          2'd1:    per_size[g][l*LW +: LW] = ssat_l;
          2'd2:    per_size[g][l*LW +: LW] = usat_l;
          default: per_size[g][l*LW +: LW] = wrap_l;
        endcase
      end
    end
  end

  always_comb begin
    case (lane_sel)
      2'd0:    nxt = per_size[0];
      2'd1:    nxt = per_size[1];
      2'd2:    nxt = per_size[2];
      default: nxt = '0;
    endcase
    if (!legal) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      bad_cfg <= 1'b0;
    end else begin
      result  <= nxt;
      bad_cfg <= !legal;
    end
  end

endmodule

// File: rtl/packed_addsub_chk.sv
module packed_addsub_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic          sub_en,
  input logic [1:0]    lane_sel,
  input logic [1:0]    sat_sel,
  input logic [DW-1:0] result,
  input logic          bad_cfg
);

  logic ok_cfg;
  assign ok_cfg = (lane_sel != 2'd3) && (sat_sel != 2'd3) &&
                  !((sat_sel != 2'd0) && (lane_sel == 2'd2));

  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (result == '0 && !bad_cfg);
  end

  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_cfg |=> (bad_cfg && result == '0));

  a_r8_legal_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ok_cfg |=> !bad_cfg);

  a_r3_wrap_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cfg && sat_sel == 2'd0 && !sub_en && opb == '0) |=> result == $past(opa));

  a_r4_signed_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cfg && sat_sel == 2'd1 && opb == '0) |=> result == $past(opa));

  a_r5_unsigned_add_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sel == 2'd2 && lane_sel == 2'd0 && !sub_en) |=> result[7:0] >= $past(opa[7:0]));

  a_r6_sub_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cfg && sub_en && opa == opb) |=> result == '0);

endmodule

bind packed_addsub packed_addsub_chk #(.DW(DW)) u_chk (.*);

// File: tb/packed_addsub_test.sv
module packed_addsub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        sub_en = 1'b0;
  logic [1:0]  lane_sel = '0, sat_sel = '0;
  logic [63:0] result;
  logic        bad_cfg;

  int n_cmp = 0, n_bad = 0;

  typedef struct {
    logic [63:0] res;
    logic        err;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  packed_addsub uut (.clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .sub_en(sub_en),
                     .lane_sel(lane_sel), .sat_sel(sat_sel), .result(result), .bad_cfg(bad_cfg));

  function automatic void model(input logic [63:0] a, input logic [63:0] b, input logic s,
                                input logic [1:0] ls, input logic [1:0] ss,
                                output logic [63:0] r, output logic e);
    int lw;
    longint x, y, z, mask, lo, hi;
    r = '0;
    e = (ls == 3) || (ss == 3) || (ss != 0 && ls == 2);
    if (e) return;
    lw = 8 << ls;
    mask = (64'sd1 <<< lw) - 1;
    for (int i = 0; i < 64 / lw; i++) begin
      x = longint'((a >> (i * lw))) & mask;
      y = longint'((b >> (i * lw))) & mask;
      if (ss == 1) begin
        if (x[lw-1]) x = x - (64'sd1 <<< lw);
        if (y[lw-1]) y = y - (64'sd1 <<< lw);
      end
      z = s ? x - y : x + y;
      if (ss == 1) begin
        lo = -(64'sd1 <<< (lw - 1));
        hi = (64'sd1 <<< (lw - 1)) - 1;
        if (z > hi) z = hi;
        if (z < lo) z = lo;
      end else if (ss == 2) begin
        if (z > mask) z = mask;
        if (z < 0) z = 0;
      end
      r = r | (64'((z & mask)) << (i * lw));
    end
  endfunction

  function automatic logic [63:0] fill(input longint v, input logic [1:0] ls);
    int lw;
    logic [63:0] r;
    lw = (ls == 3) ? 8 : (8 << ls);
    r = '0;
    for (int i = 0; i < 64 / lw; i++) r = r | ((64'(v) & ((64'd1 << lw) - 1)) << (i * lw));
    return r;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic s,
                       input logic [1:0] ls, input logic [1:0] ss);
    exp_t it;
    @(negedge clk);
    opa = a; opb = b; sub_en = s; lane_sel = ls; sat_sel = ss;
    model(a, b, s, ls, ss, it.res, it.err);
    if (it.err) it.tag = "R7";
    else if (ss == 1) it.tag = s ? "R4/R6/R8" : "R4/R8";
    else if (ss == 2) it.tag = s ? "R5/R6/R8" : "R5/R8";
    else it.tag = s ? "R2/R3/R6" : "R2/R3";
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_cmp++;
      if (result !== it.res || bad_cfg !== it.err) begin
        n_bad++;
        $display("FAIL %s: got result=%h bad_cfg=%b expected result=%h bad_cfg=%b",
                 it.tag, result, bad_cfg, it.res, it.err);
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    longint corner [5];
    repeat (3) @(negedge clk);
    n_cmp++;
    if (result !== '0 || bad_cfg !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got result=%h bad_cfg=%b expected 0 and 0", result, bad_cfg);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (result !== '0 || bad_cfg !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: after release got result=%h bad_cfg=%b expected 0 and 0", result, bad_cfg);
    end
    // R2 lane isolation: mixed lanes where a carry would leak into a neighbour
    drive(64'h00FF_7F80_FFFF_0001, 64'h0001_0180_0001_FFFF, 1'b0, 2'd0, 2'd0);
    drive(64'h00FF_7F80_FFFF_0001, 64'h0001_0180_0001_FFFF, 1'b1, 2'd1, 2'd0);
    for (int s = 0; s < 2; s++)
      for (int ls = 0; ls < 4; ls++)
        for (int ss = 0; ss < 4; ss++) begin
          int lw;
          lw = (ls == 3) ? 8 : (8 << ls);
          corner[0] = 0;
          corner[1] = 1;
          corner[2] = (64'sd1 <<< (lw - 1)) - 1;
          corner[3] = 64'sd1 <<< (lw - 1);
          corner[4] = (64'sd1 <<< lw) - 1;
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              drive(fill(corner[i], 2'(ls)), fill(corner[j], 2'(ls)), 1'(s), 2'(ls), 2'(ss));
          for (int k = 0; k < 12; k++)
            drive({$urandom, $urandom}, {$urandom, $urandom}, 1'(s), 2'(ls), 2'(ss));
        end
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule